// File: doc/BRIEF.md
# Serial 001 Pattern Watcher

This block watches a one-bit serial stream, taking one bit on each rising clock edge, and raises a flag whenever the three most recent bits are zero, zero, one. The flag is built in one of two forms, and the form is chosen when the design is elaborated.

The three-state form raises the flag in the same cycle that the closing one is on the input. In this form the flag is a function of the stored state and the live input. The four-state form uses a dedicated hit state, so its flag comes only from the stored state. As a result it appears one clock later and does not move when the input changes within a cycle.

A synchronous reset clears any zeros the block has already counted. Any run of two or more zeros counts as the prefix of a match. A one that closes a match also starts the search again.

Top module: `trio_zero_one_watch`

## Requirements
- R1: With reset sampled high, both forms return to the idle state. In the cycle after reset is released, the flag is low, even when the input is 1.
- R2: In the three-state form, the flag is 1 in any cycle whose input is 1, provided the two bits sampled before it were both 0 and no reset came in between.
- R3: In the three-state form, the flag is 0 in every other cycle.
- R4: In the four-state form, a flag is never high for two cycles in a row. The flag is 0 after any edge that did not complete a zero, zero, one sequence.
- R5: In the four-state form, the flag holds steady when the input changes between clock edges.
- R6: A run of three or more zeros followed by a 1 gives exactly one flag.
- R7: Matches that follow each other directly are each flagged. The stream 0,0,1,0,0,1 gives two flags.
- R8: A reset that arrives after two zeros discards them. A 1 right after the reset gives no flag.
- R9: The four-state flag equals the three-state flag one clock later, for the same input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, sampled on each rising edge |
| match_out | output | 1 | Pattern flag; its timing depends on the chosen form |

## Verification
In the three-state form the flag is combinational, so the bench drives each bit on the falling edge and samples the flag 1 ns later, inside the same cycle. In the four-state form the flag is due one rising edge after the closing 1. The bench therefore checks it at the next falling edge, before driving the next bit, against the three-state expectation it saved for the previous cycle. It also toggles the input in the middle of each cycle and checks the four-state flag again. Expected values come from a count of trailing zeros that saturates at two.

// File: rtl/trio_watch_pkg.sv
package trio_watch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ZERO1 = 2'b01,
        ST_ZERO2 = 2'b10,
        ST_HIT   = 2'b11
    } watch_state_e;

    // three-state next state; the spare code 11 falls back to idle
    function automatic watch_state_e step_three(input watch_state_e cur, input logic b);
        watch_state_e nxt;
        unique case (cur)
            ST_IDLE:  nxt = b ? ST_IDLE : ST_ZERO1;
            ST_ZERO1: nxt = b ? ST_IDLE : ST_ZERO2;
            ST_ZERO2: nxt = b ? ST_IDLE : ST_ZERO2;
            default:  nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // four-state next state; a closing one enters the hit state
    function automatic watch_state_e step_four(input watch_state_e cur, input logic b);
        watch_state_e nxt;
        unique case (cur)
            ST_IDLE:  nxt = b ? ST_IDLE : ST_ZERO1;
            ST_ZERO1: nxt = b ? ST_IDLE : ST_ZERO2;
            ST_ZERO2: nxt = b ? ST_HIT  : ST_ZERO2;
            default:  nxt = b ? ST_IDLE : ST_ZERO1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/trio_state_reg.sv
module trio_state_reg
    import trio_watch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  watch_state_e nxt_state,
    output watch_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_IDLE;
        else     cur_state <= nxt_state;
    end
endmodule

// File: rtl/trio_next_logic.sv
module trio_next_logic
    import trio_watch_pkg::*;
#(
    parameter bit MOORE_FORM = 1'b0
) (
    input  watch_state_e cur_state,
    input  logic         bit_in,
    output watch_state_e nxt_state
);
    generate
        if (MOORE_FORM) begin : g_four
            always_comb nxt_state = step_four(cur_state, bit_in);
        end else begin : g_three
            always_comb nxt_state = step_three(cur_state, bit_in);
        end
    endgenerate
endmodule

// File: rtl/trio_flag_decode.sv
module trio_flag_decode
    import trio_watch_pkg::*;
#(
    parameter bit MOORE_FORM = 1'b0
) (
    input  watch_state_e cur_state,
    input  logic         bit_in,
    output logic         flag
);
    generate
        if (MOORE_FORM) begin : g_state_only
            always_comb flag = (cur_state == ST_HIT);
        end else begin : g_state_and_input
            always_comb flag = (cur_state == ST_ZERO2) && bit_in;
        end
    endgenerate
endmodule

// File: rtl/trio_zero_one_watch.sv
module trio_zero_one_watch
    import trio_watch_pkg::*;
#(
    parameter bit MOORE_FORM = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);
    watch_state_e cur_state;
    watch_state_e nxt_state;

    trio_next_logic #(.MOORE_FORM(MOORE_FORM)) u_next (
        .cur_state (cur_state),
        .bit_in    (bit_in),
        .nxt_state (nxt_state)
    );

    trio_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    trio_flag_decode #(.MOORE_FORM(MOORE_FORM)) u_flag (
        .cur_state (cur_state),
        .bit_in    (bit_in),
        .flag      (match_out)
    );
endmodule

// File: rtl/trio_zero_one_watch_chk.sv
module trio_zero_one_watch_chk #(
    parameter bit MOORE_FORM = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic bit_in,
    input logic match_out
);
    // independent observer: trailing zero count saturating at two
    logic [1:0] zrun;
    logic       due_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun    <= 2'd0;
            due_hit <= 1'b0;
        end else begin
            due_hit <= (zrun == 2'd2) && bit_in;
            zrun    <= bit_in ? 2'd0 : ((zrun == 2'd2) ? 2'd2 : zrun + 2'd1);
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !match_out);

    generate
        if (MOORE_FORM) begin : g_four
            a_r9_delayed_flag: assert property (@(posedge clk) disable iff (rst)
                due_hit |-> match_out);
            a_r4_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
                !due_hit |-> !match_out);
            a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
                match_out |=> !match_out);
        end else begin : g_three
            a_r2_same_cycle_flag: assert property (@(posedge clk) disable iff (rst)
                ((zrun == 2'd2) && bit_in) |-> match_out);
            a_r3_no_false_flag: assert property (@(posedge clk) disable iff (rst)
                !((zrun == 2'd2) && bit_in) |-> !match_out);
        end
    endgenerate
endmodule

bind trio_zero_one_watch trio_zero_one_watch_chk #(.MOORE_FORM(MOORE_FORM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .match_out (match_out)
);

// File: tb/trio_zero_one_watch_bench.sv
module trio_zero_one_watch_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit_mealy;
    logic hit_moore;

    int checks = 0;
    int errors = 0;
    int mealy_hits = 0;
    int zeros = 0;
    logic moore_exp = 1'b0;

    always #4 clk = ~clk;

    trio_zero_one_watch #(.MOORE_FORM(1'b0)) u_trio_zero_one_watch (
        .clk(clk), .rst(rst), .bit_in(din), .match_out(hit_mealy));

    trio_zero_one_watch #(.MOORE_FORM(1'b1)) u_trio_zero_one_watch_moore (
        .clk(clk), .rst(rst), .bit_in(din), .match_out(hit_moore));

    function automatic logic expect_flag(input int z, input logic b);
        return (z >= 2) && b;
    endfunction

    function automatic int next_zeros(input int z, input logic b);
        if (b) return 0;
        return (z >= 2) ? 2 : z + 1;
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic b, input string extra = "");
        logic e;
        @(negedge clk);
        chk(hit_moore, moore_exp, moore_exp ? "R9" : "R4");
        din = b;
        #1;
        e = expect_flag(zeros, b);
        chk(hit_mealy, e, e ? "R2" : "R3");
        if (extra != "") chk(hit_mealy, e, extra);
        din = ~b;
        #1;
        chk(hit_moore, moore_exp, "R5");
        din = b;
        if (e) mealy_hits++;
        moore_exp = e;
        zeros = next_zeros(zeros, b);
    endtask

    task automatic do_reset(input logic b);
        @(negedge clk);
        rst = 1'b1;
        din = b;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        din = 1'b1;
        #1;
        chk(hit_mealy, 1'b0, "R1");
        chk(hit_moore, 1'b0, "R1");
        zeros = 0;
        moore_exp = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5EED_0017));
        repeat (2) @(posedge clk);
        do_reset(1'b0);
        step(1'b1, "R1");

        // R6: long zero run then one
        base = mealy_hits;
        step(1'b0); step(1'b0); step(1'b0); step(1'b0); step(1'b0);
        step(1'b1, "R6");
        step(1'b1);
        chk_int(mealy_hits - base, 1, "R6");

        // R7: back-to-back matches
        base = mealy_hits;
        step(1'b0); step(1'b0); step(1'b1, "R7");
        step(1'b0); step(1'b0); step(1'b1, "R7");
        step(1'b0);
        chk_int(mealy_hits - base, 2, "R7");

        // R8: reset after two zeros discards them
        step(1'b0); step(1'b0);
        do_reset(1'b0);
        step(1'b1, "R8");
        step(1'b0);

        // mixed random stream, biased toward zeros
        for (int i = 0; i < 3000; i++) begin
            logic b;
            b = (($urandom % 3) == 0);
            if (($urandom % 400) == 0) do_reset(b);
            step(b);
        end
        step(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule